// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs the strobe timing of a processor's external memory and I/O bus. When a request arrives while the bus is idle, the block registers the address and asserts one strobe. It then holds that strobe for a base cycle plus a programmed number of internal wait states. If that wait count is two or more, it can extend the access further while an external ready line reads low. Ready is captured on the falling clock edge. Before the last programmed internal wait state, ready cannot affect the access.

A qualifier input selects between memory space and I/O space. Memory accesses can also be marked as data-space accesses. A data-space access clears the upper address bits on the bus. An I/O access uses its own strobe, which asserts half a clock later than a memory strobe would. A wait indicator, active low and changed only on falling edges, marks the stretched part of the access. A one-cycle completion pulse marks the edge where the strobe releases.

Top module: `ext_wait_ctl`

## Requirements
- R1: While rst_n is low, mem_stb_n and io_stb_n are 1, wait_n is 1, done is 0 and bus_addr is 0.
- R2: A request sampled high on a rising edge while idle registers addr on bus_addr at that edge; for a memory access (io_sel=0) mem_stb_n goes to 0 on that same edge.
- R3: When data_sel=1 and io_sel=0, bus_addr bits 19:16 are 0 for the whole access, whatever addr holds.
- R4: With ready high at every falling edge, the strobe stays low for exactly wait_cnt+1 clock cycles.
- R5: wait_cnt is taken at acceptance; changing it during an access does not change the access length.
- R6: With wait_cnt of 0 or 1, a low ready never lengthens the access.
- R7: With wait_cnt of 2 or more, each falling edge from the one in the last programmed wait cycle onward that samples ready low adds one cycle; the strobe releases on the rising edge after the first such falling edge that samples ready high.
- R8: Ready low in the base cycle or in any programmed wait cycle before the last one has no effect on the access length.
- R9: Ready is sampled only on falling edges; ready low around a rising edge but high at the falling edge has no effect.
- R10: For io_sel=1, io_stb_n goes low at the falling edge of the acceptance cycle and rises on the same rising edge a memory strobe would; mem_stb_n stays 1, and the two strobes are never low together.
- R11: wait_n goes low at the falling edge of the base cycle when the access continues past the next rising edge, and returns high at the falling edge of the final strobe cycle; it stays high for a one-cycle access.
- R12: done is 1 for exactly the one cycle after the rising edge where the strobe releases; a request held high during an access is ignored, and the next one is accepted no earlier than the rising edge after that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, sampled while idle |
| io_sel | input | 1 | 1 selects I/O space, 0 memory space |
| data_sel | input | 1 | Marks a memory access as data space |
| addr | input | 20 | Requested address |
| wait_cnt | input | 3 | Internal wait-state count (0 to 7) |
| ready | input | 1 | External ready, low extends the access |
| bus_addr | output | 20 | Registered external address |
| mem_stb_n | output | 1 | Memory strobe, active low |
| io_stb_n | output | 1 | I/O strobe, active low |
| wait_n | output | 1 | Wait-state indicator, active low |
| done | output | 1 | Completion pulse |

## Verification
For a request set up before rising edge E0, bus_addr and the memory strobe are due in the cycle after E0. The I/O strobe is due only after the falling edge in that cycle. The strobe release and the done pulse come on the rising edge L cycles after E0, where the bench computes L from the wait count and the ready pattern. wait_n changes only on falling edges. For this reason the bench reads strobes, address and done 5 ns after each rising edge, and reads wait_n and the I/O strobe 5 ns after each falling edge. It changes ready 2 ns after a rising edge, so the level at the falling edge is settled. For the falling-edge test it also drives glitches that reach only the rising edge.

// File: rtl/ext_wait_ctl.sv
module ext_wait_ctl #(
  parameter int AW     = 20,
  parameter int WW     = 3,
  parameter int PW     = 4,
  parameter int MIN_HW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          io_sel,
  input  logic          data_sel,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wait_cnt,
  input  logic          ready,
  output logic [AW-1:0] bus_addr,
  output logic          mem_stb_n,
  output logic          io_stb_n,
  output logic          wait_n,
  output logic          done
);
  localparam int            LOW_W  = AW - PW;
  localparam logic [WW-1:0] HW_MIN = WW'(MIN_HW);

  logic          active;
  logic [WW-1:0] rem;
  logic [WW-1:0] w_l;
  logic          io_l;
  logic          ds_l;
  logic          rdy_q;
  logic          io_q;
  logic          wt_q;
  logic          done_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_in;
  logic          hw_ok;
  logic          ds_in;

  assign ds_in   = data_sel & ~io_sel;
  assign addr_in = ds_in ? {{PW{1'b0}}, addr[LOW_W-1:0]} : addr;
  assign hw_ok   = (w_l >= HW_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem    <= '0;
      w_l    <= '0;
      io_l   <= 1'b0;
      ds_l   <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (req) begin
          active <= 1'b1;
          rem    <= wait_cnt;
          w_l    <= wait_cnt;
          io_l   <= io_sel;
          ds_l   <= ds_in;
          addr_q <= addr_in;
        end
      end else if (rem != '0) begin
        rem <= rem - 1'b1;
      end else if (!(hw_ok && !rdy_q)) begin
        active <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      io_q  <= 1'b0;
      wt_q  <= 1'b0;
    end else begin
      rdy_q <= ready;
      io_q  <= active & io_l;
      wt_q  <= active & ((rem != '0) | (hw_ok & ~ready));
    end
  end

  assign mem_stb_n = ~(active & ~io_l);
  assign io_stb_n  = ~(active & io_l & io_q);
  assign wait_n    = ~wt_q;
  assign done      = done_q;
  assign bus_addr  = addr_q;
endmodule

// File: rtl/ext_wait_chk.sv
module ext_wait_chk #(
  parameter int AW     = 20,
  parameter int WW     = 3,
  parameter int PW     = 4,
  parameter int MIN_HW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_stb_n,
  input logic          io_stb_n,
  input logic          wait_n,
  input logic          done,
  input logic [AW-1:0] bus_addr,
  input logic          active,
  input logic [WW-1:0] rem,
  input logic [WW-1:0] w_l,
  input logic          ds_l,
  input logic          rdy_q
);
  localparam logic [WW-1:0] HW_MIN = WW'(MIN_HW);

  always @(negedge clk)
    if (!rst_n) AST_RESET_IDLE: assert (mem_stb_n && io_stb_n && wait_n && !done); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_stb_n && !io_stb_n)); // R10

  AST_DS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ds_l) |-> (bus_addr[AW-1:AW-PW] == '0)); // R3

  AST_WCNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(w_l)); // R5

  AST_SW_WAIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rem != '0) |=> active); // R8

  AST_HW_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rem == '0 && w_l >= HW_MIN && !rdy_q) |=> active); // R7

  AST_NO_HW_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rem == '0 && w_l < HW_MIN) |=> !active); // R6

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(active) && mem_stb_n && io_stb_n)); // R12
endmodule

bind ext_wait_ctl ext_wait_chk #(.AW(AW), .WW(WW), .PW(PW), .MIN_HW(MIN_HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_stb_n(mem_stb_n), .io_stb_n(io_stb_n),
  .wait_n(wait_n), .done(done), .bus_addr(bus_addr), .active(active),
  .rem(rem), .w_l(w_l), .ds_l(ds_l), .rdy_q(rdy_q)
);

// File: tb/sim_ext_wait_ctl.sv
module sim_ext_wait_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        io_sel = 1'b0;
  logic        data_sel = 1'b0;
  logic [19:0] addr = '0;
  logic [2:0]  wait_cnt = '0;
  logic        ready = 1'b1;
  logic [19:0] bus_addr;
  logic        mem_stb_n, io_stb_n, wait_n, done;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ext_wait_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .io_sel(io_sel), .data_sel(data_sel),
    .addr(addr), .wait_cnt(wait_cnt), .ready(ready), .bus_addr(bus_addr),
    .mem_stb_n(mem_stb_n), .io_stb_n(io_stb_n), .wait_n(wait_n), .done(done)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input logic [2:0] w, input logic [31:0] pat);
    int k;
    if (w < 3'd2) return int'(w) + 1;
    k = int'(w);
    while (k < 31 && !pat[k]) k++;
    return k + 1;
  endfunction

  task automatic run_acc(input bit io, input bit ds, input logic [19:0] a, input logic [2:0] w,
                         input logic [31:0] pat, input bit glitch, input string tag);
    int len;
    logic [19:0] ea;
    len = exp_len(w, pat);
    ea = (ds && !io) ? {4'h0, a[15:0]} : a;
    @(negedge clk); #1;
    req = 1'b1; io_sel = io; data_sel = ds; addr = a; wait_cnt = w; ready = pat[0];
    @(posedge clk); #2;
    req = 1'b0; wait_cnt = ~w; addr = ~a; ready = pat[0];
    #3;
    chk(ds ? "R3" : "R2", "bus_addr", 32'(bus_addr), 32'(ea));
    for (int k = 0; k < len; k++) begin
      if (k > 0) begin
        @(posedge clk); #2; ready = pat[k]; #3;
      end
      if (io) begin
        chk("R10", "mem_stb_n during io", 32'(mem_stb_n), 32'd1);
        chk("R10", "io_stb_n after rise", 32'(io_stb_n), (k == 0) ? 32'd1 : 32'd0);
      end else begin
        chk(tag, "mem_stb_n held", 32'(mem_stb_n), 32'd0);
        chk("R2", "io_stb_n during mem", 32'(io_stb_n), 32'd1);
      end
      #10;
      chk("R11", "wait_n after fall", 32'(wait_n), (k < len - 1) ? 32'd0 : 32'd1);
      if (io) chk("R10", "io_stb_n after fall", 32'(io_stb_n), 32'd0);
      if (glitch) ready = 1'b0;
    end
    @(posedge clk); #2; ready = 1'b1; #3;
    chk(tag, "mem_stb_n released", 32'(mem_stb_n), 32'd1);
    chk(tag, "io_stb_n released", 32'(io_stb_n), 32'd1);
    chk("R12", "done at release", 32'(done), 32'd1);
    @(posedge clk); #5;
    chk("R12", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    #25;
    chk("R1", "mem_stb_n in reset", 32'(mem_stb_n), 32'd1);
    chk("R1", "io_stb_n in reset", 32'(io_stb_n), 32'd1);
    chk("R1", "wait_n in reset", 32'(wait_n), 32'd1);
    chk("R1", "done in reset", 32'(done), 32'd0);
    chk("R1", "bus_addr in reset", 32'(bus_addr), 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_back_to_back;
    @(negedge clk); #1;
    req = 1'b1; io_sel = 1'b0; data_sel = 1'b0; addr = 20'h1_2345; wait_cnt = 3'd0;
    @(posedge clk); #2; addr = 20'h5_4321; #3;
    chk("R12", "first strobe", 32'(mem_stb_n), 32'd0);
    chk("R12", "first addr", 32'(bus_addr), 32'h1_2345);
    @(posedge clk); #5;
    chk("R12", "release with req held", 32'(mem_stb_n), 32'd1);
    chk("R12", "addr kept during release", 32'(bus_addr), 32'h1_2345);
    chk("R12", "done at release", 32'(done), 32'd1);
    @(posedge clk); #2; req = 1'b0; #3;
    chk("R12", "second strobe", 32'(mem_stb_n), 32'd0);
    chk("R12", "second addr", 32'(bus_addr), 32'h5_4321);
    @(posedge clk); #5;
    chk("R12", "second release", 32'(mem_stb_n), 32'd1);
    @(posedge clk); #5;
    chk("R12", "stays idle", 32'(mem_stb_n), 32'd1);
  endtask

  initial begin
    t_reset();
    run_acc(1'b0, 1'b0, 20'hA_BCDE, 3'd0, 32'h0, 1'b0, "R6");
    run_acc(1'b0, 1'b0, 20'h3_0001, 3'd1, 32'h0, 1'b0, "R6");
    run_acc(1'b0, 1'b1, 20'hF_FFFF, 3'd2, 32'hFFFF_FFFF, 1'b0, "R4");
    run_acc(1'b0, 1'b0, 20'h8_0F0F, 3'd7, 32'hFFFF_FFFF, 1'b0, "R5");
    run_acc(1'b0, 1'b1, 20'h7_7777, 3'd2, 32'hFFFF_FFE3, 1'b0, "R7");
    run_acc(1'b0, 1'b0, 20'h2_468A, 3'd3, 32'hFFFF_FFF8, 1'b0, "R8");
    run_acc(1'b0, 1'b0, 20'h1_1111, 3'd2, 32'hFFFF_FFFF, 1'b1, "R9");
    run_acc(1'b1, 1'b1, 20'hC_0042, 3'd3, 32'hFFFF_FFF7, 1'b0, "R10");
    run_acc(1'b1, 1'b0, 20'h0_0010, 3'd0, 32'hFFFF_FFFF, 1'b0, "R11");
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule